// File: doc/BRIEF.md
# Minimal UART with Register Interface

This block is a small serial port for a system bus. Software reaches it through eleven word-addressed registers. The first eight are placed like those of a 16550, so a driver written for that layout finds the data, interrupt, line and modem registers where it expects them.

Bytes written to the data register go into an eight-entry transmit queue. A transmit state machine sends each byte as one start bit, seven or eight data bits with the least significant bit first, and one stop bit. There is no parity bit. A receive state machine rebuilds frames from the serial input and places the bytes in an eight-entry receive queue. Software drains that queue by reading the data register.

Each serial bit lasts 8 × divisor clock cycles, with the divisor taken from a 16-bit register. The receiver and the transmitter are switched on and off separately, the request-to-send output is set by software, and the clear-to-send input can be read back. Two interrupt sources, receive data waiting and transmitter ready, drive one interrupt line. That line is gated by two extra enable bits.

The state machines are as follows:
- **Transmitter:** TX_IDLE → TX_START when the transmitter is on and a byte is queued. TX_START → TX_DATA after one bit time. TX_DATA → TX_STOP after the last data bit. TX_STOP → TX_IDLE after one bit time.
- **Receiver:** RX_IDLE → RX_START when the receiver is on and the line goes low. RX_START → RX_DATA if the line is still low half a bit time later, otherwise RX_START → RX_IDLE. RX_DATA → RX_STOP after the last data bit. RX_STOP → RX_IDLE one bit time later, and the byte is stored at that point.

Top module: `mini_uart`

## Requirements
- R1: After reset the registers read as follows. Line status reads 0x60, interrupt enable 0, identify 0, line control 0, modem control 0, scratch 0, extra control 0x03, extra status 0x02 and divisor 1. The outputs are txd=1, rts=0 and irq=0.
- R2: In 8-bit mode (line control bits [1:0] = 3), a frame on txd is one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts 8 × divisor clocks, and a divisor of 0 acts as 1. The receiver returns the same byte when it reads that waveform.
- R3: When line control bits [1:0] are not 3, frames carry 7 data bits. Bit 7 of a transmitted byte is not sent, and a received byte reads back with bit 7 = 0.
- R4: The data register is at offset 0. A write queues a byte for transmit and a read takes the oldest received byte. Each queue holds 8 bytes in first-in, first-out order. A write while the transmit queue is full is dropped.
- R5: A byte received while the receive queue is full is dropped and sets overrun, which is line status bit 1. Overrun stays set until line status (offset 5) is read.
- R6: Line status (offset 5) has four flags. Bit 0 is set when receive data is waiting. Bit 5 is set when the transmit queue can accept a byte. Bit 6 is set when the transmit queue is empty and no frame is being sent.
- R7: The extra control register is at offset 8. Bit 0 switches the receiver on: while it is 0, frames on rxd are ignored. Bit 1 switches the transmitter on: while it is 0, queued bytes are held and txd stays high.
- R8: The interrupt enable register is at offset 1 and reads back bits [3:0]. irq is high only when bits 2 and 3 are both set and either bit 0 is set with receive data waiting, or bit 1 is set with room in the transmit queue.
- R9: The interrupt identify register (offset 2) reads as follows:
  - When no enabled interrupt is pending, it reads 0.
  - When the receive source is pending, it reads 0x05: bit 0 pending plus bit 2 receive. The receive source wins if both sources are pending.
  - When only the transmitter-ready source is pending, it reads 0x03: bit 0 pending plus bit 1 transmit.

  Writing 1 to bit 1 empties the receive queue, and writing 1 to bit 2 empties the transmit queue.
- R10: Line control bit 6 holds txd low (break) for as long as it is set.
- R11: Modem control (offset 4) bit 1 drives rts. Modem status (offset 6) bit 5 reads cts, which passes through a two-flop synchroniser.
- R12: Register bits that are not implemented ignore writes and read as 0. Line control keeps bits 6, 1 and 0, and modem control keeps bit 1. The scratch register (offset 7) keeps 8 bits and the divisor (offset 10) keeps 16 bits.
- R13: Extra status (offset 9) has two flags. Bit 0 is set when receive data is waiting, and bit 1 is set when the transmit queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle. A read of offset 0 takes a byte from the receive queue; a read of offset 5 clears overrun |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at bus_addr, valid in the same cycle |
| irq | output | 1 | Interrupt request, active high, level |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rts | output | 1 | Request-to-send, set by software |
| cts | input | 1 | Clear-to-send, readable by software |

## Verification
A counter or bit index that is off by one in either state machine changes the bit time or the number of data bits. That error shows on txd within the first frame, and in the byte read back one bit time after the stop bit. A wrong queue pointer or a wrong overrun flag shows in the first read after the queue fills: the bytes come back out of order, or line status bit 1 is wrong. Errors in the interrupt gating or in the order of the identify sources show on irq and in the identify value in the cycle after the enable register is written.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int DIV_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int Q_DEPTH = 8;
    localparam int CNT_W   = DIV_W + 3;

    localparam logic [3:0] OFS_DATA  = 4'd0;
    localparam logic [3:0] OFS_IEN   = 4'd1;
    localparam logic [3:0] OFS_IID   = 4'd2;
    localparam logic [3:0] OFS_LINE  = 4'd3;
    localparam logic [3:0] OFS_MCTL  = 4'd4;
    localparam logic [3:0] OFS_LSTAT = 4'd5;
    localparam logic [3:0] OFS_MSTAT = 4'd6;
    localparam logic [3:0] OFS_SCR   = 4'd7;
    localparam logic [3:0] OFS_XCTL  = 4'd8;
    localparam logic [3:0] OFS_XSTAT = 4'd9;
    localparam logic [3:0] OFS_DIV   = 4'd10;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [AW:0]   cnt;
    logic do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] bit_cycles,
    input  logic             eight,
    input  logic             brk,
    input  logic             have_data,
    input  logic [7:0]       data,
    output logic             pop,
    output logic             busy,
    output logic             txd
);
    tx_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    logic last;

    assign last = (cnt == bit_cycles - 1'b1);
    assign pop  = (state_q == TX_IDLE) && (state_d == TX_START);
    assign busy = (state_q != TX_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (en && have_data) state_d = TX_START;
            TX_START: if (last) state_d = TX_DATA;
            TX_DATA:  if (last && idx == (eight ? 3'd7 : 3'd6)) state_d = TX_STOP;
            TX_STOP:  if (last) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            cnt <= (last || state_q == TX_IDLE) ? '0 : cnt + 1'b1;
            if (pop) begin
                shreg <= data;
                idx   <= '0;
            end else if (state_q == TX_DATA && last) begin
                shreg <= {1'b0, shreg[7:1]};
                idx   <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
        if (brk) txd = 1'b0;
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] bit_cycles,
    input  logic             eight,
    input  logic             rxd_s,
    output logic             push,
    output logic [7:0]       data
);
    rx_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    logic tick;

    always_comb begin
        if (state_q == RX_START) tick = (cnt == (bit_cycles >> 1) - 1'b1);
        else                     tick = (cnt == bit_cycles - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (en && !rxd_s) state_d = RX_START;
            RX_START: if (tick) state_d = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && idx == (eight ? 3'd7 : 3'd6)) state_d = RX_STOP;
            RX_STOP:  if (tick) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else begin
            cnt <= (tick || state_q == RX_IDLE) ? '0 : cnt + 1'b1;
            if (state_q == RX_START) begin
                idx <= '0;
            end else if (state_q == RX_DATA && tick) begin
                shreg <= {rxd_s, shreg[7:1]};
                idx   <= idx + 1'b1;
            end
        end
    end

    assign push = (state_q == RX_STOP) && tick;
    assign data = eight ? shreg : {1'b0, shreg[7:1]};
endmodule

// File: rtl/mini_uart.sv
module mini_uart
    import uart_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        txd,
    input  logic        rxd,
    output logic        rts,
    input  logic        cts
);
    logic [3:0]       ier_q;
    logic [1:0]       wlen_q;
    logic             lcr_brk;
    logic             rts_q;
    logic [7:0]       scr_q;
    logic [1:0]       xctl_q;
    logic [DIV_W-1:0] div_q;
    logic             ovr_q;
    logic [1:0]       rxd_sync, cts_sync;

    logic eight, lsr_rd, wr_iid, rx_flush, tx_flush;
    logic rx_push, rx_empty, rx_full, tx_pop, tx_empty, tx_full, tx_busy;
    logic [7:0] rx_byte, rx_head, tx_head;
    logic [CNT_W-1:0] bit_cycles;
    logic rx_src, tx_src, gate;
    logic [7:0] iir_val, lsr_val;

    assign eight      = (wlen_q == 2'b11);
    assign bit_cycles = {(div_q == '0) ? DIV_W'(1) : div_q, 3'b000};
    assign lsr_rd     = bus_rd && bus_addr == OFS_LSTAT;
    assign wr_iid     = bus_wr && bus_addr == OFS_IID;
    assign rx_flush   = wr_iid && bus_wdata[1];
    assign tx_flush   = wr_iid && bus_wdata[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q    <= '0;
            wlen_q   <= '0;
            lcr_brk  <= 1'b0;
            rts_q    <= 1'b0;
            scr_q    <= '0;
            xctl_q   <= 2'b11;
            div_q    <= DIV_W'(1);
            ovr_q    <= 1'b0;
            rxd_sync <= 2'b11;
            cts_sync <= 2'b00;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd};
            cts_sync <= {cts_sync[0], cts};
            if (bus_wr) begin
                case (bus_addr)
                    OFS_IEN:  ier_q <= bus_wdata[3:0];
                    OFS_LINE: begin
                        wlen_q  <= bus_wdata[1:0];
                        lcr_brk <= bus_wdata[6];
                    end
                    OFS_MCTL: rts_q  <= bus_wdata[1];
                    OFS_SCR:  scr_q  <= bus_wdata[7:0];
                    OFS_XCTL: xctl_q <= bus_wdata[1:0];
                    OFS_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
                    default:  ;
                endcase
            end
            if (rx_push && rx_full && !rx_flush) ovr_q <= 1'b1;
            else if (lsr_rd)                     ovr_q <= 1'b0;
        end
    end

    uart_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .din(rx_byte),
        .pop(bus_rd && bus_addr == OFS_DATA),
        .head(rx_head), .empty(rx_empty), .full(rx_full));

    uart_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(bus_wr && bus_addr == OFS_DATA), .din(bus_wdata[7:0]),
        .pop(tx_pop),
        .head(tx_head), .empty(tx_empty), .full(tx_full));

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(xctl_q[1]), .bit_cycles(bit_cycles),
        .eight(eight), .brk(lcr_brk), .have_data(!tx_empty), .data(tx_head),
        .pop(tx_pop), .busy(tx_busy), .txd(txd));

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(xctl_q[0]), .bit_cycles(bit_cycles),
        .eight(eight), .rxd_s(rxd_sync[1]), .push(rx_push), .data(rx_byte));

    assign gate   = ier_q[2] && ier_q[3];
    assign rx_src = gate && ier_q[0] && !rx_empty;
    assign tx_src = gate && ier_q[1] && !tx_full && !rx_src;
    assign irq    = rx_src || tx_src;
    assign iir_val = {5'b0, rx_src, tx_src, irq};
    assign lsr_val = {1'b0, tx_empty && !tx_busy, !tx_full, 3'b0, ovr_q, !rx_empty};
    assign rts    = rts_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA:  bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            OFS_IEN:   bus_rdata[3:0] = ier_q;
            OFS_IID:   bus_rdata[7:0] = iir_val;
            OFS_LINE:  bus_rdata[7:0] = {1'b0, lcr_brk, 4'b0, wlen_q};
            OFS_MCTL:  bus_rdata[1]   = rts_q;
            OFS_LSTAT: bus_rdata[7:0] = lsr_val;
            OFS_MSTAT: bus_rdata[5]   = cts_sync[1];
            OFS_SCR:   bus_rdata[7:0] = scr_q;
            OFS_XCTL:  bus_rdata[1:0] = xctl_q;
            OFS_XSTAT: bus_rdata[1:0] = {!tx_full, !rx_empty};
            OFS_DIV:   bus_rdata[DIV_W-1:0] = div_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_checker.sv
module uart_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       txd,
    input logic       brk,
    input logic [3:0] ier,
    input logic [2:0] iir,
    input logic       ovr,
    input logic       lsr_rd,
    input logic       tx_busy
);
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ier[2] && ier[3]));

    p_iid_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(iir[1] && iir[2]));

    p_iid_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[1] || iir[2]) |-> irq);

    p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !lsr_rd) |=> ovr);

    p_idle_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !brk) |-> txd);
endmodule

bind mini_uart uart_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .txd(txd), .brk(lcr_brk),
    .ier(ier_q), .iir(iir_val[2:0]), .ovr(ovr_q), .lsr_rd(lsr_rd),
    .tx_busy(tx_busy));

// File: tb/mini_uart_test.sv
`timescale 1ns/1ps
module mini_uart_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic irq, txd, rts;
    logic cts = 1'b0;
    logic loop = 1'b0;
    logic rxd_drv = 1'b1;
    logic rxd;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    assign rxd = loop ? txd : rxd_drv;
    always #2 clk = ~clk;

    mini_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .txd(txd), .rxd(rxd), .rts(rts), .cts(cts));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int cyc(input int div);
        return 8 * ((div == 0) ? 1 : div);
    endfunction

    function automatic logic [7:0] fold(input logic [7:0] b, input bit eight);
        return eight ? b : {1'b0, b[6:0]};
    endfunction

    task automatic mon_tx(input int div, input int nbits, output logic [7:0] b);
        int guard = 0;
        b = '0;
        @(negedge clk);
        while (txd == 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (cyc(div) / 2) @(negedge clk);
        chk("R2 start bit", int'(txd), 0);
        for (int i = 0; i < nbits; i++) begin
            repeat (cyc(div)) @(negedge clk);
            b[i] = txd;
        end
        repeat (cyc(div)) @(negedge clk);
        chk("R2 stop bit", int'(txd), 1);
    endtask

    task automatic drive_rx(input int div, input int nbits, input logic [7:0] b);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (cyc(div)) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd_drv = b[i];
            repeat (cyc(div)) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (cyc(div) + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0] got, b;
        logic [7:0] q[8];
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd5, d);  chk("R1 line status", int'(d), 'h60);
        rd(4'd1, d);  chk("R1 int enable", int'(d), 0);
        rd(4'd2, d);  chk("R1 int identify", int'(d), 0);
        rd(4'd8, d);  chk("R1 extra control", int'(d), 3);
        rd(4'd9, d);  chk("R1 extra status", int'(d), 2);
        rd(4'd10, d); chk("R1 divisor", int'(d), 1);
        rd(4'd7, d);  chk("R1 scratch", int'(d), 0);
        chk("R1 txd/rts/irq", int'({txd, rts, irq}), 'b100);

        // R12 storage and unused bits
        b = 8'($urandom);
        wr(4'd7, {8'hFF, b}); rd(4'd7, d); chk("R12 scratch", int'(d), int'(b));
        wr(4'd3, 16'hFFFF); rd(4'd3, d); chk("R12 line control bits", int'(d), 'h43);
        wr(4'd3, 16'h0003);
        wr(4'd1, 16'hFFFF); rd(4'd1, d); chk("R12 int enable bits", int'(d), 'hF);
        wr(4'd1, 16'h0000);
        wr(4'd10, 16'hA5C3); rd(4'd10, d); chk("R12 divisor", int'(d), 'hA5C3);
        wr(4'd4, 16'hFFFF); rd(4'd4, d); chk("R12 modem control bits", int'(d), 2);
        chk("R11 rts high", int'(rts), 1);
        wr(4'd4, 16'h0000);
        chk("R11 rts low", int'(rts), 0);

        // R11 cts readback
        cts = 1'b1; repeat (3) @(negedge clk);
        rd(4'd6, d); chk("R11 cts high", int'(d), 'h20);
        cts = 1'b0; repeat (3) @(negedge clk);
        rd(4'd6, d); chk("R11 cts low", int'(d), 0);

        // R2 R4 R6 loopback in 8-bit mode at several divisors
        loop = 1'b1;
        for (int dv = 1; dv <= 3; dv++) begin
            wr(4'd10, 16'(dv));
            for (int k = 0; k < 4; k++) begin
                b = 8'($urandom);
                if (k == 0) b = 8'hFF;
                if (k == 1) b = 8'h00;
                wr(4'd0, {8'h00, b});
                mon_tx(dv, 8, got);
                chk("R2 serial byte", int'(got), int'(b));
                repeat (cyc(dv) + 8) @(negedge clk);
                rd(4'd5, d); chk("R6 rx ready", int'(d), 'h61);
                rd(4'd9, d); chk("R13 extra status", int'(d), 3);
                rd(4'd0, d); chk("R4 received byte", int'(d), int'(b));
            end
        end

        // R3 7-bit mode
        wr(4'd3, 16'h0000);
        wr(4'd10, 16'd2);
        for (int k = 0; k < 4; k++) begin
            b = (k == 0) ? 8'hFF : 8'($urandom);
            wr(4'd0, {8'h00, b});
            mon_tx(2, 7, got);
            chk("R3 seven-bit serial", int'(got), int'(fold(b, 1'b0)));
            repeat (cyc(2) + 8) @(negedge clk);
            rd(4'd0, d); chk("R3 seven-bit read", int'(d), int'(fold(b, 1'b0)));
        end

        // R5 overrun and R4 ordering
        loop = 1'b0;
        wr(4'd3, 16'h0003);
        wr(4'd10, 16'd1);
        for (int k = 0; k < 9; k++) begin
            b = 8'($urandom);
            if (k < 8) q[k] = b;
            drive_rx(1, 8, b);
        end
        rd(4'd5, d); chk("R5 overrun set", int'(d), 'h63);
        rd(4'd5, d); chk("R5 overrun cleared by read", int'(d), 'h61);
        for (int k = 0; k < 8; k++) begin
            rd(4'd0, d); chk("R4 fifo order", int'(d), int'(q[k]));
        end
        rd(4'd5, d); chk("R5 ninth byte dropped", int'(d), 'h60);

        // R7 transmitter off, R4 transmit depth
        wr(4'd8, 16'h0001);
        for (int k = 0; k < 9; k++) begin
            b = 8'($urandom);
            if (k < 8) q[k] = b;
            wr(4'd0, {8'h00, b});
        end
        rd(4'd5, d); chk("R6 tx full not idle", int'(d), 0);
        repeat (100) @(negedge clk);
        chk("R7 txd held high", int'(txd), 1);
        wr(4'd8, 16'h0003);
        for (int k = 0; k < 8; k++) begin
            mon_tx(1, 8, got);
            chk("R4 tx fifo order", int'(got), int'(q[k]));
        end
        repeat (20) @(negedge clk);
        rd(4'd5, d); chk("R4 ninth tx byte dropped", int'(d), 'h60);

        // R7 receiver off
        wr(4'd8, 16'h0002);
        drive_rx(1, 8, 8'h5A);
        rd(4'd5, d); chk("R7 receiver ignores line", int'(d), 'h60);
        wr(4'd8, 16'h0003);

        // R8 R9 interrupts
        drive_rx(1, 8, 8'h3C);
        wr(4'd1, 16'h0001);
        chk("R8 irq needs gate bits", int'(irq), 0);
        wr(4'd1, 16'h000D);
        chk("R8 irq rx", int'(irq), 1);
        rd(4'd2, d); chk("R9 identify rx", int'(d), 5);
        wr(4'd1, 16'h000F);
        rd(4'd2, d); chk("R9 rx has priority", int'(d), 5);
        wr(4'd2, 16'h0002);
        rd(4'd5, d); chk("R9 rx flush", int'(d), 'h60);
        rd(4'd2, d); chk("R9 identify tx", int'(d), 3);
        wr(4'd1, 16'h000C);
        chk("R8 irq off", int'(irq), 0);
        rd(4'd2, d); chk("R9 identify none", int'(d), 0);
        wr(4'd1, 16'h0000);
        wr(4'd8, 16'h0001);
        wr(4'd0, 16'h0011);
        wr(4'd0, 16'h0022);
        wr(4'd2, 16'h0004);
        rd(4'd5, d); chk("R9 tx flush", int'(d), 'h60);
        wr(4'd8, 16'h0003);
        repeat (20) @(negedge clk);
        chk("R9 flushed bytes not sent", int'(txd), 1);

        // R10 break
        wr(4'd3, 16'h0043);
        chk("R10 break low", int'(txd), 0);
        wr(4'd3, 16'h0003);
        chk("R10 break released", int'(txd), 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule